// File: doc/BRIEF.md
# Region Boundary Hint Recorder

This block sits beside one processor core and writes out the marks that cut a multi-core run into regions. Every core's regions follow one global order. Each mark, called a hint, holds a region number and the number of memory operations the core has retired so far. An offline analysis that rebuilds the order of shared-memory accesses uses these marks to limit its search to one region at a time.

Two boundary policies are available, and the policy is chosen at reset. The timed policy closes a region every N clock cycles on this core's own timer and needs no wiring between cores. The coherence policy counts the coherence downgrade requests that reach the core. When the count reaches a threshold, the block closes a region and drives a broadcast pulse. It also closes a region whenever another core's pulse arrives, so every core's k-th hint refers to the same boundary.

Top module: `region_hint_recorder`

## Requirements
- R1: While reset is held, hintValid and boundaryOut are 0 and hintRegion and hintCount read 0.
- R2: modeSel (0 = timed, 1 = coherence), periodCfg and thresholdCfg are captured on clock edges where rstN is low. Changing them after reset has no effect on the output.
- R3: In timed mode with period N ≥ 1, hintValid pulses for one cycle on the N-th cycle after reset release and every N cycles after that, whatever the other inputs do.
- R4: In timed mode, downgradeReq and boundaryIn have no effect and boundaryOut stays 0.
- R5: In coherence mode with threshold T ≥ 1, the T-th downgrade request since the last boundary creates a boundary. In the cycle after that request, hintValid and boundaryOut are both 1 for one cycle, and the downgrade count restarts at 0.
- R6: In coherence mode, boundaryIn high in a cycle gives a hint in the next cycle with boundaryOut 0 (unless R5 also fires). It clears the downgrade count, and any downgrade request in that same cycle is discarded.
- R7: When a local threshold crossing and boundaryIn fall in the same cycle, exactly one hint is produced, and boundaryOut is 1 with it.
- R8: hintCount equals the number of cycles with memOpRetire high since reset, counting cycles before the boundary cycle and excluding it. Hints never reset this count.
- R9: hintRegion is 0 on the first hint after reset and rises by 1 on each later hint, wrapping modulo 2^16.
- R10: In coherence mode, no hint appears in a cycle unless the previous cycle had boundaryIn or a threshold crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| modeSel | input | 1 | Boundary policy: 0 timed, 1 coherence |
| periodCfg | input | TIMER_W | Timed-mode period N in cycles |
| thresholdCfg | input | DG_W | Coherence-mode downgrade threshold T |
| memOpRetire | input | 1 | One memory operation retired this cycle |
| downgradeReq | input | 1 | One coherence downgrade request received this cycle |
| boundaryIn | input | 1 | Boundary pulse broadcast by another core |
| boundaryOut | output | 1 | Boundary pulse this core broadcasts on a local threshold crossing |
| hintValid | output | 1 | A hint record is present this cycle |
| hintRegion | output | 16 | Region number of the hint |
| hintCount | output | CNT_W | Cumulative memory-operation count of the hint |

## Verification
The timed policy is run with random retire, downgrade and broadcast traffic, both at period 1 and at a longer period. This shows that the timer alone sets the hint times and that the cross-core inputs are ignored. The coherence policy gets random downgrade and broadcast traffic at several thresholds, which separates hints caused locally from hints caused remotely through boundaryOut. Directed sequences then place a crossing and a remote pulse in the same cycle, let a remote pulse clear a partial count, and change the configuration pins after reset. A long run at period 1 drives the region number through its wrap.

// File: rtl/region_hint_pkg.sv
package region_hint_pkg;

  localparam int REGION_W = 16;

  typedef enum logic {
    MODE_TIMED  = 1'b0,
    MODE_COHERE = 1'b1
  } bound_mode_e;

  // Strobes handed from the boundary control to the hint datapath.
  typedef struct packed {
    logic boundary;   // a region closes in this cycle
    logic broadcast;  // the closing was caused locally and must be sent to the other cores
  } ctrl_strobe_t;

endpackage

// File: rtl/region_hint_ctrl.sv
module region_hint_ctrl
  import region_hint_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int DG_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSel,
  input  logic [TIMER_W-1:0] periodCfg,
  input  logic [DG_W-1:0]    thresholdCfg,
  input  logic               downgradeReq,
  input  logic               boundaryIn,
  output bound_mode_e        cfgMode,
  output ctrl_strobe_t       strobes
);

  logic [TIMER_W-1:0] cfgPeriod;
  logic [DG_W-1:0]    cfgThr;
  logic [TIMER_W-1:0] cycleTimer;
  logic [DG_W-1:0]    dgCount;

  logic timerExpire;
  logic localCross;
  logic remoteHit;
  logic anyBoundary;

  always_comb begin
    timerExpire = (cfgMode == MODE_TIMED) && (cycleTimer == cfgPeriod - TIMER_W'(1));
    localCross  = (cfgMode == MODE_COHERE) && downgradeReq && (dgCount == cfgThr - DG_W'(1));
    remoteHit   = (cfgMode == MODE_COHERE) && boundaryIn;
    anyBoundary = timerExpire || localCross || remoteHit;
    strobes.boundary  = anyBoundary;
    strobes.broadcast = localCross;
  end

  // Configuration capture happens only while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode   <= bound_mode_e'(modeSel);
      cfgPeriod <= periodCfg;
      cfgThr    <= thresholdCfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleTimer <= '0;
      dgCount    <= '0;
    end else if (cfgMode == MODE_TIMED) begin
      cycleTimer <= timerExpire ? '0 : cycleTimer + TIMER_W'(1);
      dgCount    <= '0;
    end else begin
      cycleTimer <= '0;
      if (anyBoundary) begin
        dgCount <= '0;
      end else if (downgradeReq) begin
        dgCount <= dgCount + DG_W'(1);
      end
    end
  end

endmodule

// File: rtl/region_hint_datapath.sv
module region_hint_datapath
  import region_hint_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                memOpRetire,
  input  ctrl_strobe_t        strobes,
  output logic                hintValid,
  output logic                boundaryOut,
  output logic [REGION_W-1:0] hintRegion,
  output logic [CNT_W-1:0]    hintCount
);

  logic [CNT_W-1:0]    memCount;
  logic [REGION_W-1:0] regionIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCount    <= '0;
      regionIdx   <= '0;
      hintValid   <= 1'b0;
      boundaryOut <= 1'b0;
      hintRegion  <= '0;
      hintCount   <= '0;
    end else begin
      memCount    <= memCount + CNT_W'(memOpRetire);
      hintValid   <= strobes.boundary;
      boundaryOut <= strobes.broadcast;
      if (strobes.boundary) begin
        regionIdx  <= regionIdx + REGION_W'(1);
        hintRegion <= regionIdx;
        hintCount  <= memCount;
      end
    end
  end

endmodule

// File: rtl/region_hint_recorder.sv
module region_hint_recorder
  import region_hint_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int DG_W    = 8,
  parameter int CNT_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSel,
  input  logic [TIMER_W-1:0]  periodCfg,
  input  logic [DG_W-1:0]     thresholdCfg,
  input  logic                memOpRetire,
  input  logic                downgradeReq,
  input  logic                boundaryIn,
  output logic                boundaryOut,
  output logic                hintValid,
  output logic [REGION_W-1:0] hintRegion,
  output logic [CNT_W-1:0]    hintCount
);

  bound_mode_e  cfgMode;
  ctrl_strobe_t strobes;

  region_hint_ctrl #(.TIMER_W(TIMER_W), .DG_W(DG_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeSel      (modeSel),
    .periodCfg    (periodCfg),
    .thresholdCfg (thresholdCfg),
    .downgradeReq (downgradeReq),
    .boundaryIn   (boundaryIn),
    .cfgMode      (cfgMode),
    .strobes      (strobes)
  );

  region_hint_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .memOpRetire (memOpRetire),
    .strobes     (strobes),
    .hintValid   (hintValid),
    .boundaryOut (boundaryOut),
    .hintRegion  (hintRegion),
    .hintCount   (hintCount)
  );

endmodule

// File: rtl/region_hint_checker.sv
module region_hint_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgMode,
  input logic             downgradeReq,
  input logic             boundaryIn,
  input logic             hintValid,
  input logic             boundaryOut,
  input logic [15:0]      hintRegion,
  input logic [CNT_W-1:0] hintCount
);

  logic [15:0]      expRegion;
  logic [CNT_W-1:0] lastCount;
  logic             seenHint;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expRegion <= '0;
      lastCount <= '0;
      seenHint  <= 1'b0;
    end else if (hintValid) begin
      expRegion <= expRegion + 16'd1;
      lastCount <= hintCount;
      seenHint  <= 1'b1;
    end
  end

  a_r5_out_has_hint: assert property (@(posedge clk) disable iff (!rstN)
    boundaryOut |-> hintValid);

  a_r4_timed_no_broadcast: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |-> !boundaryOut);

  a_r6_remote_gives_hint: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && boundaryIn) |=> hintValid);

  a_r10_no_spurious_hint: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && !downgradeReq && !boundaryIn) |=> !hintValid);

  a_r9_region_sequence: assert property (@(posedge clk) disable iff (!rstN)
    hintValid |-> (hintRegion == expRegion));

  a_r8_count_nondecreasing: assert property (@(posedge clk) disable iff (!rstN)
    (hintValid && seenHint) |-> (hintCount >= lastCount));

endmodule

bind region_hint_recorder region_hint_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgMode      (cfgMode),
  .downgradeReq (downgradeReq),
  .boundaryIn   (boundaryIn),
  .hintValid    (hintValid),
  .boundaryOut  (boundaryOut),
  .hintRegion   (hintRegion),
  .hintCount    (hintCount)
);

// File: tb/region_hint_recorder_bench.sv
module region_hint_recorder_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic [15:0] periodCfg = 16'd1;
  logic [7:0]  thresholdCfg = 8'd1;
  logic        memOpRetire = 1'b0;
  logic        downgradeReq = 1'b0;
  logic        boundaryIn = 1'b0;
  logic        boundaryOut;
  logic        hintValid;
  logic [15:0] hintRegion;
  logic [31:0] hintCount;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;
  bit scrambleCfg = 1'b0;
  string tagOverride = "";

  // Reference state built from the requirements.
  logic        mMode;
  logic [15:0] mPeriod, mTimer, mRegion;
  logic [7:0]  mThr, mDg;
  logic [31:0] mMem;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_hint_recorder u_region_hint_recorder (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .periodCfg(periodCfg),
    .thresholdCfg(thresholdCfg), .memOpRetire(memOpRetire),
    .downgradeReq(downgradeReq), .boundaryIn(boundaryIn),
    .boundaryOut(boundaryOut), .hintValid(hintValid),
    .hintRegion(hintRegion), .hintCount(hintCount)
  );

  task automatic checkEq(input string tag, input string what, input longint act, input longint exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string validTag(input logic mode, input logic localX, input logic bin);
    if (tagOverride != "") return tagOverride;
    if (!mode) return "R3";
    if (localX && bin) return "R7";
    if (bin) return "R6";
    if (localX) return "R5";
    return "R10";
  endfunction

  // Called at a falling edge; leaves at the next falling edge.
  task automatic doReset(input logic mode, input logic [15:0] per, input logic [7:0] thr);
    rstN = 1'b0; modeSel = mode; periodCfg = per; thresholdCfg = thr;
    memOpRetire = $urandom_range(0, 1); downgradeReq = $urandom_range(0, 1); boundaryIn = $urandom_range(0, 1);
    repeat (2) @(negedge clk);
    checkEq("R1", "hintValid in reset", hintValid, 0);
    checkEq("R1", "boundaryOut in reset", boundaryOut, 0);
    checkEq("R1", "hintRegion in reset", hintRegion, 0);
    checkEq("R1", "hintCount in reset", hintCount, 0);
    rstN = 1'b1;
    mMode = mode; mPeriod = per; mThr = thr;
    mTimer = '0; mDg = '0; mMem = '0; mRegion = '0;
  endtask

  task automatic stepCycle(input logic ret, input logic dg, input logic bin);
    logic localX, boundary;
    memOpRetire = ret; downgradeReq = dg; boundaryIn = bin;
    if (scrambleCfg) begin
      modeSel = $urandom_range(0, 1);
      periodCfg = 16'($urandom_range(1, 7));
      thresholdCfg = 8'($urandom_range(1, 7));
    end
    if (!mMode) begin
      localX = 1'b0;
      boundary = (mTimer == mPeriod - 16'd1);
    end else begin
      localX = dg && (mDg == mThr - 8'd1);
      boundary = localX || bin;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    checkEq(validTag(mMode, localX, bin), "hintValid", hintValid, boundary);
    checkEq(mMode ? "R5" : "R4", "boundaryOut", boundaryOut, localX);
    if (boundary) begin
      checkEq("R9", "hintRegion", hintRegion, mRegion);
      checkEq("R8", "hintCount", hintCount, mMem);
    end
    mMem = mMem + 32'(ret);
    if (boundary) mRegion = mRegion + 16'd1;
    if (!mMode) mTimer = boundary ? 16'd0 : mTimer + 16'd1;
    else        mDg = boundary ? 8'd0 : (dg ? mDg + 8'd1 : mDg);
    @(negedge clk);
  endtask

  task automatic randomRun(input int cycles, input int dgPct, input int binPct);
    for (int i = 0; i < cycles; i++) begin
      stepCycle($urandom_range(0, 1),
                $urandom_range(0, 99) < dgPct,
                $urandom_range(0, 99) < binPct);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(20240611);
    @(negedge clk);

    // Timed mode, longer period, busy cross-core inputs (R3, R4).
    doReset(1'b0, 16'd5, 8'd2);
    randomRun(80, 50, 30);

    // Timed mode, period 1: hint every cycle.
    doReset(1'b0, 16'd1, 8'd1);
    randomRun(20, 40, 40);

    // Configuration pins changed after reset must not matter (R2).
    doReset(1'b0, 16'd4, 8'd3);
    scrambleCfg = 1'b1; tagOverride = "R2";
    randomRun(40, 60, 60);
    doReset(1'b1, 16'd2, 8'd3);
    randomRun(60, 50, 10);
    scrambleCfg = 1'b0; tagOverride = "";

    // Coherence mode, random traffic at several thresholds (R5, R6, R10).
    doReset(1'b1, 16'd3, 8'd3);
    randomRun(150, 40, 8);
    doReset(1'b1, 16'd3, 8'd1);
    randomRun(60, 30, 10);
    doReset(1'b1, 16'd9, 8'd5);
    randomRun(150, 60, 5);

    // Directed: crossing and remote pulse together (R7).
    doReset(1'b1, 16'd3, 8'd2);
    stepCycle(1, 1, 0);
    stepCycle(1, 1, 1);
    stepCycle(0, 0, 0);
    // Directed: remote pulse clears a partial count (R6).
    stepCycle(1, 1, 0);
    stepCycle(0, 0, 1);
    stepCycle(1, 1, 0);
    stepCycle(0, 0, 0);
    stepCycle(1, 1, 0);
    // Remote pulse discards a same-cycle request (R6).
    stepCycle(0, 1, 1);
    stepCycle(0, 1, 0);
    stepCycle(0, 1, 0);

    // Region number wrap (R9).
    doReset(1'b0, 16'd1, 8'd1);
    tagOverride = "R9";
    randomRun(65540, 0, 0);
    tagOverride = "";

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule